// File: doc/BRIEF.md
# Game Pad Capture Controller

This block captures a 16-bit button word into two byte-wide data registers that a processor reads over a small register port. The processor starts a capture in one of two ways. A timed capture begins on one control write, holds a busy flag for a fixed number of clock cycles and then latches the button word. The processor may cancel it before it finishes. A stepped capture is driven entirely by the processor. It arms a down-counter and then writes the control register again and again, alternating one clock bit. Only writes that carry the level the counter expects move the counter, and the last such write latches the button word.

The register port has three byte registers, selected by a 2-bit address: control at 0, low data byte at 1 and high data byte at 2. Address 3 reads zero. The data registers are read-only. The button input has a companion valid flag. While that flag is low, the word is taken as all zeros.

Top module: `pad_capture`

## Requirements
- R1: After reset, all addresses read 0x00, the busy bit (control bit 1) is 0, no timed capture is pending and no stepped capture is armed.
- R2: A control write stores bits 7..2 and bit 0 of the written byte, with bit 2 forced to 1. Bit 1 is not writable and reads the busy flag. Writes to addresses 1, 2 and 3 have no effect, and address 3 reads 0x00.
- R3: A control write with bit 2 set and bit 0 clear, made while idle, sets busy. Exactly HW_READ_LEN clock edges after the write edge, the input is latched: low byte to address 1, high byte to address 2. Busy then clears.
- R4: A start write made while a timed capture is pending keeps busy set and does not move the completion edge, because the earlier deadline always wins.
- R5: A control write with bit 0 set cancels any pending timed capture. Busy clears and no latch follows, even when the abort lands on the completion edge. A write with both bit 2 and bit 0 set starts nothing.
- R6: A control write with bit 5 set loads the stepped counter with 31, or re-loads it if already armed, and leaves the data registers unchanged.
- R7: While armed, a control write counts only if its bit 4 equals 1 when the counter is odd and 0 when it is even. A counting write decrements the counter; any other write leaves it unchanged.
- R8: A counting write made at count 0 latches the input into the data registers and disarms the stepped capture. Sixteen set/clear pairs of bit 4 after arming complete one capture, and further toggling latches nothing.
- R9: When the input valid flag is low at a latch, both data registers receive 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 low data, 2 high data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| btn_state | input | 16 | Button word to capture |
| btn_valid | input | 1 | Button word present; low means capture zeros |

## Verification
The bench sets HW_READ_LEN to 5, so every cycle of a timed capture can be checked for busy and for unchanged data, and the completion edge is pinned exactly. With this short window, restarts, aborts two cycles in, and an abort landing on the completion edge itself can all be covered. The stepped capture keeps its full 32-step length. The bench sweeps several button words and several patterns of injected non-counting writes through it, including a re-arm partway through.

// File: rtl/pad_pkg.sv
package pad_pkg;
    localparam int PAD_W        = 16;
    localparam int CTL_SW_INIT  = 5;
    localparam int CTL_SW_CLK   = 4;
    localparam int CTL_HW_REQ   = 2;
    localparam int CTL_BUSY     = 1;
    localparam int CTL_ABORT    = 0;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DLO  = 2'd1,
        ADDR_DHI  = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pad_hw_timer.sv
module pad_hw_timer #(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int RW = $clog2(LEN + 1);

    typedef struct packed {
        logic          pending;
        logic [RW-1:0] rem;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (abort) begin
            st_d.pending = 1'b0;
            st_d.rem     = '0;
        end else if (st_q.pending && st_q.rem == RW'(1)) begin
            done         = 1'b1;
            st_d.pending = 1'b0;
            st_d.rem     = '0;
        end else if (st_q.pending) begin
            // earlier deadline wins: a restart never moves it
            st_d.rem = st_q.rem - RW'(1);
        end else if (start) begin
            st_d.pending = 1'b1;
            st_d.rem     = RW'(LEN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.pending;

    a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |-> (st_q.rem >= RW'(1) && st_q.rem <= RW'(LEN)));
    a_r3_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && !st_q.pending) |=> (busy && st_q.rem == RW'(LEN)));
    a_r4_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && st_q.pending && st_q.rem != RW'(1)) |=>
        (busy && st_q.rem == $past(st_q.rem) - RW'(1)));
    a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
    a_r5_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !done);
endmodule

// File: rtl/pad_sw_seq.sv
module pad_sw_seq #(
    parameter int BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic init,
    input  logic clk_bit,
    output logic active,
    output logic done
);
    localparam int STEPS = 2 * BITS;
    localparam int CW    = $clog2(STEPS);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic match;

    assign match = (clk_bit == st_q.cnt[0]);

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (wr) begin
            if (init) begin
                st_d.armed = 1'b1;
                st_d.cnt   = CW'(STEPS - 1);
            end else if (st_q.armed && match) begin
                if (st_q.cnt == '0) begin
                    done       = 1'b1;
                    st_d.armed = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.armed;

    a_r6_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && init) |=> (active && st_q.cnt == CW'(STEPS - 1)));
    a_r7_mismatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !init && st_q.armed && clk_bit != st_q.cnt[0]) |=>
        (active && $stable(st_q.cnt)));
    a_r8_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);
    a_r8_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> !done);
endmodule

// File: rtl/pad_capture.sv
module pad_capture
    import pad_pkg::*;
#(
    parameter int HW_READ_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [15:0] btn_state,
    input  logic        btn_valid
);
    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] dlo;
        logic [7:0] dhi;
    } regs_t;

    regs_t rg_d, rg_q;

    logic ctrl_wr, hw_start, hw_abort, hw_busy, hw_done;
    logic sw_active, sw_done, latch;
    logic [PAD_W-1:0] cap_word;

    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign hw_abort = ctrl_wr && reg_wdata[CTL_ABORT];
    assign hw_start = ctrl_wr && reg_wdata[CTL_HW_REQ] && !reg_wdata[CTL_ABORT];

    pad_hw_timer #(.LEN(HW_READ_LEN)) u_hw (
        .clk   (clk),
        .rst_n (rst_n),
        .start (hw_start),
        .abort (hw_abort),
        .busy  (hw_busy),
        .done  (hw_done)
    );

    pad_sw_seq #(.BITS(PAD_W)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .init    (reg_wdata[CTL_SW_INIT]),
        .clk_bit (reg_wdata[CTL_SW_CLK]),
        .active  (sw_active),
        .done    (sw_done)
    );

    assign latch    = hw_done || sw_done;
    assign cap_word = btn_valid ? btn_state : '0;

    always_comb begin
        rg_d = rg_q;
        if (ctrl_wr) begin
            rg_d.ctrl             = reg_wdata;
            rg_d.ctrl[CTL_HW_REQ] = 1'b1;
            rg_d.ctrl[CTL_BUSY]   = 1'b0;
        end
        if (latch) begin
            rg_d.dlo = cap_word[7:0];
            rg_d.dhi = cap_word[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata           = rg_q.ctrl;
                reg_rdata[CTL_BUSY] = hw_busy;
            end
            ADDR_DLO:  reg_rdata = rg_q.dlo;
            ADDR_DHI:  reg_rdata = rg_q.dhi;
            default:   reg_rdata = 8'h00;
        endcase
    end

    a_r2_req_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> rg_q.ctrl[CTL_HW_REQ]);
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> ($stable(rg_q.dlo) && $stable(rg_q.dhi)));
    a_r9_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !btn_valid) |=> (rg_q.dlo == 8'h00 && rg_q.dhi == 8'h00));
    a_r5_start_when_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_abort && !sw_done) |=> $stable(rg_q.dlo));
    a_r6_arm_on_init: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[CTL_SW_INIT]) |=> sw_active);
endmodule

// File: tb/pad_capture_tb_top.sv
module pad_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW_LEN     = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] btn_state = 16'h0000;
    logic        btn_valid = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [15:0] held;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pad_capture #(.HW_READ_LEN(HW_LEN)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .btn_state (btn_state),
        .btn_valid (btn_valid)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step();
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %02h expected %02h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_data(input string req, input logic [15:0] exp);
        chk(req, 2'd1, exp[7:0]);
        chk(req, 2'd2, exp[15:8]);
    endtask

    task automatic chk_busy(input string req, input logic exp);
        reg_addr = 2'd0;
        #1;
        checks++;
        if (reg_rdata[1] !== exp) begin
            errors++;
            $display("FAIL %s busy actual %0b expected %0b", req, reg_rdata[1], exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        for (int a = 0; a < 4; a++) chk("R1", 2'(a), 8'h00);

        // R2 stored bits, bit2 forced, data writes ignored
        wr(2'd0, 8'hC8); chk("R2", 2'd0, 8'hCC);
        wr(2'd0, 8'hC9); chk("R2", 2'd0, 8'hCD);
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        chk_data("R2", 16'h0000); chk("R2", 2'd3, 8'h00);

        // R3 timed capture over several words
        held = 16'h0000;
        for (int p = 0; p < 6; p++) begin
            btn_state = 16'h1234 * 16'(p + 1) ^ 16'hA5C3;
            wr(2'd0, 8'h04);
            for (int i = 0; i < HW_LEN - 1; i++) begin
                chk_busy("R3", 1'b1);
                chk_data("R3", held);
                step();
            end
            step();
            chk_busy("R3", 1'b0);
            held = btn_state;
            btn_state = ~btn_state;
            chk_data("R3", held);
        end

        // R4 restart while pending keeps first deadline
        btn_state = 16'h5A0F;
        wr(2'd0, 8'h04);
        step();
        wr(2'd0, 8'h04);
        for (int i = 0; i < HW_LEN - 3; i++) step();
        chk_busy("R4", 1'b1); chk_data("R4", held);
        step();
        chk_busy("R4", 1'b0); chk_data("R4", 16'h5A0F);
        held = 16'h5A0F;

        // R5 abort mid-way, on completion edge, and with start bit
        btn_state = 16'h7E81;
        wr(2'd0, 8'h04); step();
        wr(2'd0, 8'h01); chk_busy("R5", 1'b0);
        repeat (HW_LEN + 2) step();
        chk_data("R5", held);
        wr(2'd0, 8'h04);
        for (int i = 0; i < HW_LEN - 1; i++) step();
        wr(2'd0, 8'h01);
        chk_busy("R5", 1'b0); chk_data("R5", held);
        repeat (2) step(); chk_data("R5", held);
        wr(2'd0, 8'h05); chk_busy("R5", 1'b0);
        repeat (HW_LEN + 1) step(); chk_data("R5", held);

        // R6 R7 R8 stepped capture with injected non-counting writes
        for (int p = 0; p < 4; p++) begin
            btn_state = 16'h0F1E + 16'(p) * 16'h3333;
            wr(2'd0, 8'h20);
            chk_data("R6", held);
            if (p[0]) wr(2'd0, 8'h00);
            for (int k = 0; k < 16; k++) begin
                wr(2'd0, 8'h10);
                if (p >= 2 && k % 3 == 0) wr(2'd0, 8'h10);
                if (k == 15) chk_data("R7", held);
                else wr(2'd0, 8'h00);
                if (p == 3 && k == 4) wr(2'd0, 8'h00);
            end
            wr(2'd0, 8'h00);
            held = btn_state;
            chk_data("R8", held);
        end
        // R8 further toggles latch nothing
        btn_state = 16'hBEEF;
        for (int k = 0; k < 16; k++) begin wr(2'd0, 8'h10); wr(2'd0, 8'h00); end
        chk_data("R8", held);
        // R6 re-arm partway restarts the count
        btn_state = 16'hC35A;
        wr(2'd0, 8'h20);
        for (int k = 0; k < 5; k++) begin wr(2'd0, 8'h10); wr(2'd0, 8'h00); end
        wr(2'd0, 8'h20);
        for (int k = 0; k < 15; k++) begin wr(2'd0, 8'h10); wr(2'd0, 8'h00); end
        wr(2'd0, 8'h10);
        chk_data("R6", held);
        wr(2'd0, 8'h00);
        held = 16'hC35A;
        chk_data("R6", held);

        // R9 invalid input latches zero, both modes
        btn_valid = 1'b0; btn_state = 16'hFFFF;
        wr(2'd0, 8'h04);
        repeat (HW_LEN) step();
        chk_data("R9", 16'h0000);
        btn_valid = 1'b1; btn_state = 16'h1357;
        wr(2'd0, 8'h04); repeat (HW_LEN) step();
        chk_data("R9", 16'h1357);
        btn_valid = 1'b0;
        wr(2'd0, 8'h20);
        for (int k = 0; k < 16; k++) begin wr(2'd0, 8'h10); wr(2'd0, 8'h00); end
        chk_data("R9", 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule